// File: doc/BRIEF.md
# Multi-Branch Hamming Frame Decoder

This block sits behind an 18-bit deserializer and rebuilds a 36-bit protected frame from two successive words. The first word of a frame carries a start flag. The frame holds three independent single-error-correcting codewords: two full-length 15-bit Hamming codewords and one 6-bit codeword, which is a 7-bit Hamming code with its highest position removed.

Each codeword is decoded in parallel. The block computes a syndrome for each one, inverts the bit that the syndrome points at, and extracts the message bits. The 25 recovered bits (11 + 11 + 3) and two flags per branch are registered. They are presented for one cycle, one clock after the second word is accepted. Because every branch corrects its own error, a frame that has one flipped bit in each of the three codewords is still recovered in full. Out-of-order words are dropped and reported as framing errors.

Top module: `mhd_frame_decoder`

## Requirements
- R1: Word 0 is accepted only with `first_i` high. Its bits [14:0] are codeword A and its bits [17:15] are bits [2:0] of codeword C. The next word with `first_i` low is word 1. Its bits [14:0] are codeword B and its bits [17:15] are bits [5:3] of codeword C.
- R2: In each codeword, 1-based position p is held in bit p-1. Parity bits sit at positions 1, 2, 4 and 8 and give even parity over the positions whose index has that bit set. Message bits fill the other positions in ascending order, from message bit 0 upward. In codeword C the message bits are positions 3, 5 and 6, and the missing position 7 is treated as 0.
- R3: A frame with no errors yields `data_o = {C msg[2:0], B msg[10:0], A msg[10:0]}` with every `corrected_o` and `uncorr_o` bit low.
- R4: A single flipped bit in a codeword is repaired. That branch's `corrected_o` bit goes high (bit 0 = A, bit 1 = B, bit 2 = C). `corrected_o` and `uncorr_o` are never high for the same branch.
- R5: One flipped bit in each of the three codewords of a frame is repaired in all three branches at once.
- R6: `valid_o` pulses for exactly one cycle, in the cycle after the clock edge that accepts word 1. `corrected_o` and `uncorr_o` are zero whenever `valid_o` is low.
- R7: A word without `first_i` that arrives while word 0 is expected is discarded. `frame_err_o` then pulses for one cycle after that edge, and no frame is output.
- R8: A word with `first_i` that arrives while word 1 is expected replaces the pending word 0. `frame_err_o` pulses for one cycle after that edge.
- R9: A codeword C syndrome of 7 sets `uncorr_o[2]`. The C message bits then pass through uncorrected.
- R10: After reset, `valid_o`, `frame_err_o` and all flags are low, and the decoder expects word 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_vld_i | input | 1 | Input word strobe |
| word_i | input | 18 | Deserializer word |
| first_i | input | 1 | Marks word 0 of a frame |
| valid_o | output | 1 | Decoded frame strobe |
| data_o | output | 25 | Recovered message bits |
| corrected_o | output | 3 | Per-branch single-bit repair flag |
| uncorr_o | output | 3 | Per-branch invalid-syndrome flag |
| frame_err_o | output | 1 | Framing-error pulse |

## Verification
The embedded properties hold on every cycle for the following. The output strobe is a single-cycle pulse that never coincides with a framing error. Flags are idle whenever no frame is presented. Each branch's repair changes exactly one bit and never occurs together with an uncorrectable flag. The bench's scenarios cover the rest: the correct bit layout, actual recovery of message values under random single errors per branch, triple-error frames, the syndrome-7 pass-through of the short branch, and both kinds of out-of-order word.

// File: rtl/mhd_pkg.sv
package mhd_pkg;
  localparam int WORD_W   = 18;
  localparam int LONG_N   = 15;
  localparam int LONG_K   = 11;
  localparam int SHORT_N  = 6;
  localparam int SHORT_K  = 3;
  localparam int SPLIT_W  = WORD_W - LONG_N;
  localparam int DATA_W   = 2 * LONG_K + SHORT_K;
  localparam int BRANCHES = 3;

  typedef enum logic {
    ST_WAIT_W0 = 1'b0,
    ST_WAIT_W1 = 1'b1
  } asm_state_e;
endpackage

// File: rtl/mhd_frame_asm.sv
module mhd_frame_asm
  import mhd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_vld_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                first_i,
  output logic                frame_vld_o,
  output logic                frame_err_o,
  output logic [LONG_N-1:0]   cw_a_o,
  output logic [LONG_N-1:0]   cw_b_o,
  output logic [SHORT_N-1:0]  cw_c_o
);
  asm_state_e state_q, state_d;
  logic [WORD_W-1:0] w0_q;
  logic take_w0;

  always_comb begin
    state_d     = state_q;
    take_w0     = 1'b0;
    frame_vld_o = 1'b0;
    frame_err_o = 1'b0;
    if (word_vld_i) begin
      if (first_i) begin
        // restart on a start flag in either state
        take_w0     = 1'b1;
        state_d     = ST_WAIT_W1;
        frame_err_o = (state_q == ST_WAIT_W1);
      end else if (state_q == ST_WAIT_W1) begin
        frame_vld_o = 1'b1;
        state_d     = ST_WAIT_W0;
      end else begin
        frame_err_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_W0;
      w0_q    <= '0;
    end else begin
      state_q <= state_d;
      if (take_w0) w0_q <= word_i;
    end
  end

  assign cw_a_o = w0_q[LONG_N-1:0];
  assign cw_b_o = word_i[LONG_N-1:0];
  assign cw_c_o = {word_i[WORD_W-1:LONG_N], w0_q[WORD_W-1:LONG_N]};

  p_no_frame_on_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !frame_vld_o);
  p_w1_needs_w0_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o |-> state_q == ST_WAIT_W1);
endmodule

// File: rtl/mhd_ham_branch.sv
module mhd_ham_branch #(
  parameter int N_BITS = 15,
  parameter int K_BITS = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BITS-1:0] cw_i,
  output logic [K_BITS-1:0] data_o,
  output logic              corr_o,
  output logic              uncorr_o
);
  localparam int P_BITS = $clog2(N_BITS + 1);

  logic [P_BITS-1:0] syn;
  logic [N_BITS-1:0] fixed;

  always_comb begin
    syn = '0;
    for (int i = 1; i <= N_BITS; i++)
      if (cw_i[i-1]) syn = syn ^ P_BITS'(i);
  end

  always_comb begin
    fixed    = cw_i;
    corr_o   = 1'b0;
    uncorr_o = 1'b0;
    if (syn != '0) begin
      if (int'(syn) <= N_BITS) corr_o = 1'b1;
      else                     uncorr_o = 1'b1;
      for (int i = 1; i <= N_BITS; i++)
        if (syn == P_BITS'(i)) fixed[i-1] = ~cw_i[i-1];
    end
  end

  always_comb begin
    int k;
    k      = 0;
    data_o = '0;
    for (int i = 1; i <= N_BITS; i++) begin
      if ((i & (i - 1)) != 0) begin
        if (k < K_BITS) data_o[k] = fixed[i-1];
        k = k + 1;
      end
    end
  end

  p_single_fix_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    corr_o |-> $countones(fixed ^ cw_i) == 1);
  p_pass_through_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uncorr_o |-> fixed == cw_i);
endmodule

// File: rtl/mhd_frame_decoder.sv
module mhd_frame_decoder
  import mhd_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                word_vld_i,
  input  logic [WORD_W-1:0]   word_i,
  input  logic                first_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [BRANCHES-1:0] corrected_o,
  output logic [BRANCHES-1:0] uncorr_o,
  output logic                frame_err_o
);
  logic                frame_vld, frame_err;
  logic [LONG_N-1:0]   cw_a, cw_b;
  logic [SHORT_N-1:0]  cw_c;
  logic [LONG_K-1:0]   d_a, d_b;
  logic [SHORT_K-1:0]  d_c;
  logic [BRANCHES-1:0] corr, unc;

  mhd_frame_asm u_asm (
    .clk_i, .rst_ni, .word_vld_i, .word_i, .first_i,
    .frame_vld_o(frame_vld), .frame_err_o(frame_err),
    .cw_a_o(cw_a), .cw_b_o(cw_b), .cw_c_o(cw_c)
  );

  mhd_ham_branch #(.N_BITS(LONG_N), .K_BITS(LONG_K)) u_br_a (
    .clk_i, .rst_ni, .cw_i(cw_a), .data_o(d_a), .corr_o(corr[0]), .uncorr_o(unc[0]));
  mhd_ham_branch #(.N_BITS(LONG_N), .K_BITS(LONG_K)) u_br_b (
    .clk_i, .rst_ni, .cw_i(cw_b), .data_o(d_b), .corr_o(corr[1]), .uncorr_o(unc[1]));
  mhd_ham_branch #(.N_BITS(SHORT_N), .K_BITS(SHORT_K)) u_br_c (
    .clk_i, .rst_ni, .cw_i(cw_c), .data_o(d_c), .corr_o(corr[2]), .uncorr_o(unc[2]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      data_o      <= '0;
      corrected_o <= '0;
      uncorr_o    <= '0;
      frame_err_o <= 1'b0;
    end else begin
      valid_o     <= frame_vld;
      frame_err_o <= frame_err;
      corrected_o <= frame_vld ? corr : '0;
      uncorr_o    <= frame_vld ? unc  : '0;
      if (frame_vld) data_o <= {d_c, d_b, d_a};
    end
  end

  p_valid_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  p_idle_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (corrected_o == '0 && uncorr_o == '0));
  p_flags_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (corrected_o & uncorr_o) == '0);
  p_err_no_valid_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !valid_o);
endmodule

// File: tb/mhd_frame_decoder_tb_top.sv
module mhd_frame_decoder_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic word_vld_i = 1'b0, first_i = 1'b0;
  logic [17:0] word_i = '0;
  logic valid_o, frame_err_o;
  logic [24:0] data_o;
  logic [2:0] corrected_o, uncorr_o;
  int n_chk = 0, n_err = 0;

  always #10 clk = ~clk;

  mhd_frame_decoder dut_i (
    .clk_i(clk), .rst_ni, .word_vld_i, .word_i, .first_i,
    .valid_o, .data_o, .corrected_o, .uncorr_o, .frame_err_o);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // even-parity Hamming encoder, message bits in ascending non-power positions (R2)
  function automatic logic [14:0] enc(input logic [10:0] d, input int n);
    logic [14:0] c;
    int k;
    c = '0; k = 0;
    for (int p = 1; p <= n; p++)
      if ((p & (p - 1)) != 0) begin c[p-1] = d[k]; k++; end
    for (int j = 0; j < 4; j++)
      if ((1 << j) <= n)
        for (int p = 1; p <= n; p++)
          if (((p >> j) & 1) != 0 && p != (1 << j)) c[(1<<j)-1] ^= c[p-1];
    return c;
  endfunction

  task automatic put(input logic [17:0] w, input logic f);
    @(negedge clk);
    word_vld_i = 1'b1; word_i = w; first_i = f;
  endtask

  task automatic idle();
    @(negedge clk);
    word_vld_i = 1'b0; first_i = 1'b0;
  endtask

  // sends a frame, flips = bit masks per codeword, checks the output pulse
  task automatic frame(input logic [10:0] a, input logic [10:0] b, input logic [2:0] c,
                       input logic [14:0] fa, input logic [14:0] fb, input logic [5:0] fc,
                       input logic [24:0] exp_d, input logic [2:0] exp_c,
                       input logic [2:0] exp_u, input string req);
    logic [14:0] ca, cb;
    logic [5:0] cc;
    ca = enc(a, 15) ^ fa;
    cb = enc(b, 15) ^ fb;
    cc = enc({8'd0, c}, 6) ^ fc;
    put({cc[2:0], ca}, 1'b1);
    put({cc[5:3], cb}, 1'b0);
    idle();
    chk(valid_o === 1'b1, {req, " valid"}, 32'(valid_o), 1);
    chk(data_o === exp_d, {req, " data"}, 32'(data_o), 32'(exp_d));
    chk(corrected_o === exp_c, {req, " corrected"}, 32'(corrected_o), 32'(exp_c));
    chk(uncorr_o === exp_u, {req, " uncorr"}, 32'(uncorr_o), 32'(exp_u));
    @(negedge clk);
    chk(valid_o === 1'b0 && corrected_o === 3'b0, {req, " R6 pulse end"}, 32'(valid_o), 0);
  endtask

  initial begin
    #2_000_000;
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [10:0] a, b;
    logic [2:0] c;
    void'($urandom(32'd1234));
    #35 rst_ni = 1'b1;
    @(negedge clk);
    chk(valid_o === 0 && frame_err_o === 0 && corrected_o === 0 && uncorr_o === 0,
        "R10 reset", 32'(valid_o), 0);

    // R1 R2 R3 clean, directed layout
    frame(11'h001, 11'h400, 3'b101, '0, '0, '0, {3'b101, 11'h400, 11'h001}, 3'b0, 3'b0, "R3 clean");
    frame(11'h7ff, 11'h000, 3'b010, '0, '0, '0, {3'b010, 11'h000, 11'h7ff}, 3'b0, 3'b0, "R1 R2 layout");
    // R4 single error per branch
    frame(11'h2a5, 11'h15a, 3'b011, 15'h4000, '0, '0, {3'b011, 11'h15a, 11'h2a5}, 3'b001, 3'b0, "R4 A");
    frame(11'h2a5, 11'h15a, 3'b011, '0, 15'h0001, '0, {3'b011, 11'h15a, 11'h2a5}, 3'b010, 3'b0, "R4 B");
    frame(11'h2a5, 11'h15a, 3'b011, '0, '0, 6'h20, {3'b011, 11'h15a, 11'h2a5}, 3'b100, 3'b0, "R4 C");
    // R5 three errors in three branches
    frame(11'h0f0, 11'h70f, 3'b110, 15'h0010, 15'h0800, 6'h04, {3'b110, 11'h70f, 11'h0f0}, 3'b111, 3'b0, "R5 triple");
    // R9 syndrome 7: flip positions 1 and 6 of C; position 6 is message bit 2, passes through flipped
    frame(11'h123, 11'h321, 3'b001, '0, '0, 6'h21, {3'b101, 11'h321, 11'h123}, 3'b0, 3'b100, "R9 syn7");

    // R7 word without start flag while idle
    put(18'h3ffff, 1'b0);
    idle();
    chk(frame_err_o === 1'b1 && valid_o === 1'b0, "R7 stray word", 32'(frame_err_o), 1);
    @(negedge clk);
    chk(frame_err_o === 1'b0, "R7 err pulse end", 32'(frame_err_o), 0);
    frame(11'h055, 11'h0aa, 3'b111, '0, '0, '0, {3'b111, 11'h0aa, 11'h055}, 3'b0, 3'b0, "R7 recover");

    // R8 second start flag replaces pending word 0
    put(18'h00000, 1'b1);
    begin
      logic [14:0] ca, cb; logic [5:0] cc;
      ca = enc(11'h3c3, 15); cb = enc(11'h1e1, 15); cc = enc(11'd6, 6);
      put({cc[2:0], ca}, 1'b1);
      @(negedge clk);
      chk(frame_err_o === 1'b1 && valid_o === 1'b0, "R8 restart err", 32'(frame_err_o), 1);
      word_i = {cc[5:3], cb}; first_i = 1'b0;
      idle();
      chk(valid_o === 1'b1 && data_o === {3'd6, 11'h1e1, 11'h3c3}, "R8 new frame",
          32'(data_o), 32'({3'd6, 11'h1e1, 11'h3c3}));
    end

    // random frames, at most one error per branch (R4 R5)
    for (int it = 0; it < 60; it++) begin
      logic [14:0] fa, fb; logic [5:0] fc; logic [2:0] ec;
      a = 11'($urandom); b = 11'($urandom); c = 3'($urandom);
      fa = '0; fb = '0; fc = '0; ec = '0;
      if ($urandom_range(1)) begin fa[$urandom_range(14)] = 1'b1; ec[0] = 1'b1; end
      if ($urandom_range(1)) begin fb[$urandom_range(14)] = 1'b1; ec[1] = 1'b1; end
      if ($urandom_range(1)) begin fc[$urandom_range(5)]  = 1'b1; ec[2] = 1'b1; end
      frame(a, b, c, fa, fb, fc, {c, b, a}, ec, 3'b0, "R5 random");
      repeat ($urandom_range(2)) @(negedge clk);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule